// File: doc/BRIEF.md
# AXI4-Lite GPIO Register Slave

This block is a small AXI4-Lite target with a 32-bit data path that gives software a window onto an 8-bit input port and an 8-bit output port. One word of its address window returns the current (synchronized) input byte. A second word holds a byte that software writes and reads back. Every other word in the window is unmapped. The slave answers with distinct AXI error codes for two cases: a write aimed at the read-only word, and any access to an unmapped word.

The output pins do not simply mirror the stored byte. While the synchronized input byte is zero, the pins carry the stored byte. For any nonzero input value they carry a fixed alternating pattern (0x55 by default). A board can use this as a quick sign of life: any switch set lights a known LED pattern, and clearing all switches hands the LEDs back to software.

The write address and write data channels are accepted independently and in either order. Only one transaction is in flight per direction. Reset is synchronous and active high.

Top module: `gpio_axil_slave`

## Requirements
- R1: During and right after reset, `s_bvalid` and `s_rvalid` are low and the stored output byte is 0x00, so with the input at zero `gpo` reads 0x00.
- R2: A read of word index 0 (byte address 0x0) returns OKAY (2'b00). The data carries the synchronized input byte in bits [7:0] and zeros above.
- R3: `gpi` reaches the register logic through two flops. A change becomes visible on `gpo` and in read data two clock edges after it is applied, and not after one.
- R4: A write to word index 1 (byte address 0x4) with strobe bit 0 set stores data bits [7:0] and returns OKAY (2'b00). Bits [31:8] read back as zero whatever was written to them.
- R5: A write to word index 1 with strobe bit 0 clear returns OKAY and leaves the stored byte unchanged.
- R6: A write to word index 0 returns SLVERR (2'b10) and changes no state.
- R7: A read or write of any word index other than 0 and 1 returns DECERR (2'b11). Such a read returns all-zero data, and such a write changes no state.
- R8: While the synchronized input byte is 0x00, `gpo` equals the stored byte. Otherwise `gpo` equals 0x55.
- R9: The write address and write data may arrive together, address first, or data first. Exactly one write response follows once both are held. A channel that has already been accepted shows ready low until the response has been taken.
- R10: Once `s_bvalid` or `s_rvalid` is raised, it stays high with stable response and data until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address (byte address within the window) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte address within the window) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| gpi | input | GPIO_W | General-purpose input byte |
| gpo | output | GPIO_W | General-purpose output pins |

## Verification
The bench builds the slave with its defaults: a 12-bit address window, a 32-bit data bus and an 8-bit port on each side. At that width the stored byte and the input byte each have only 256 values, so the bench sweeps both fully. For every stored value it checks the readback and the pins with the input at zero. For every input value it checks the readback and the substituted pattern. The small window also lets the bench reach unmapped words at both ends of the address range, and it drives all three arrival orders of write address and data.

// File: rtl/gpio_axil_pkg.sv
package gpio_axil_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } axi_resp_e;

  typedef enum logic [1:0] {
    SEL_IN   = 2'd0,
    SEL_OUT  = 2'd1,
    SEL_NONE = 2'd2
  } reg_sel_e;

  localparam logic [31:0] IN_WORD  = 32'd0;
  localparam logic [31:0] OUT_WORD = 32'd1;

  function automatic reg_sel_e word_sel(input logic [31:0] idx);
    if (idx == IN_WORD)       return SEL_IN;
    else if (idx == OUT_WORD) return SEL_OUT;
    else                      return SEL_NONE;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_axil_wr.sv
module gpio_axil_wr
  import gpio_axil_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int GPIO_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                awvalid,
  output logic                awready,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic                wvalid,
  output logic                wready,
  output logic [1:0]          bresp,
  output logic                bvalid,
  input  logic                bready,
  output logic [GPIO_W-1:0]   out_q
);
  localparam int STRB_W = DATA_W / 8;

  logic              aw_held, w_held;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [STRB_W-1:0] strb_q;
  logic              commit;
  reg_sel_e          sel;
  axi_resp_e         resp_q;

  assign awready = !aw_held && !bvalid;
  assign wready  = !w_held && !bvalid;
  assign commit  = aw_held && w_held && !bvalid;
  assign sel     = word_sel(32'(addr_q[ADDR_W-1:2]));
  assign bresp   = resp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_held <= 1'b0;
      w_held  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      strb_q  <= '0;
      bvalid  <= 1'b0;
      resp_q  <= RESP_OKAY;
    end else begin
      if (awvalid && awready) begin
        aw_held <= 1'b1;
        addr_q  <= awaddr;
      end
      if (wvalid && wready) begin
        w_held <= 1'b1;
        data_q <= wdata;
        strb_q <= wstrb;
      end
      if (commit) begin
        aw_held <= 1'b0;
        w_held  <= 1'b0;
        bvalid  <= 1'b1;
        case (sel)
          SEL_OUT: resp_q <= RESP_OKAY;
          SEL_IN:  resp_q <= RESP_SLVERR;
          default: resp_q <= RESP_DECERR;
        endcase
      end
      if (bvalid && bready) bvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
    end else if (commit && sel == SEL_OUT) begin
      for (int i = 0; i < GPIO_W; i++) begin
        if (strb_q[i/8]) out_q[i] <= data_q[i];
      end
    end
  end
endmodule

// File: rtl/gpio_axil_rd.sv
module gpio_axil_rd
  import gpio_axil_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int GPIO_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  input  logic [GPIO_W-1:0] in_q,
  input  logic [GPIO_W-1:0] out_q
);
  reg_sel_e  sel;
  axi_resp_e resp_q;

  assign arready = !rvalid;
  assign sel     = word_sel(32'(araddr[ADDR_W-1:2]));
  assign rresp   = resp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      resp_q <= RESP_OKAY;
    end else begin
      if (arvalid && arready) begin
        rvalid <= 1'b1;
        case (sel)
          SEL_IN: begin
            rdata  <= DATA_W'(in_q);
            resp_q <= RESP_OKAY;
          end
          SEL_OUT: begin
            rdata  <= DATA_W'(out_q);
            resp_q <= RESP_OKAY;
          end
          default: begin
            rdata  <= '0;
            resp_q <= RESP_DECERR;
          end
        endcase
      end
      if (rvalid && rready) rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_out_sel.sv
module gpio_out_sel #(
  parameter int              GPIO_W  = 8,
  parameter logic [GPIO_W-1:0] PATTERN = 8'h55
) (
  input  logic [GPIO_W-1:0] in_q,
  input  logic [GPIO_W-1:0] out_q,
  output logic [GPIO_W-1:0] gpo
);
  always_comb begin
    if (in_q == '0) gpo = out_q;
    else            gpo = PATTERN;
  end
endmodule

// File: rtl/gpio_axil_slave.sv
module gpio_axil_slave #(
  parameter int                ADDR_W      = 12,
  parameter int                DATA_W      = 32,
  parameter int                GPIO_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [GPIO_W-1:0] PATTERN     = 8'h55
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  input  logic [GPIO_W-1:0]   gpi,
  output logic [GPIO_W-1:0]   gpo
);
  logic [GPIO_W-1:0] in_q;
  logic [GPIO_W-1:0] out_q;

  gpio_sync #(.W(GPIO_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(gpi), .q(in_q)
  );

  gpio_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GPIO_W(GPIO_W)) u_wr (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .out_q(out_q)
  );

  gpio_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GPIO_W(GPIO_W)) u_rd (
    .clk(clk), .rst(rst),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .in_q(in_q), .out_q(out_q)
  );

  gpio_out_sel #(.GPIO_W(GPIO_W), .PATTERN(PATTERN)) u_sel (
    .in_q(in_q), .out_q(out_q), .gpo(gpo)
  );
endmodule

// File: rtl/gpio_axil_chk.sv
module gpio_axil_chk #(
  parameter int                DATA_W  = 32,
  parameter int                GPIO_W  = 8,
  parameter logic [GPIO_W-1:0] PATTERN = 8'h55
) (
  input logic              clk,
  input logic              rst,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              s_wvalid,
  input logic              s_wready,
  input logic [1:0]        s_bresp,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_rresp,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [GPIO_W-1:0] gpi,
  input logic [GPIO_W-1:0] gpo
);
  logic aw_seen, w_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_seen <= 1'b0;
      w_seen  <= 1'b0;
    end else begin
      if (s_bvalid && s_bready) begin
        aw_seen <= 1'b0;
        w_seen  <= 1'b0;
      end
      if (s_awvalid && s_awready) aw_seen <= 1'b1;
      if (s_wvalid && s_wready)   w_seen  <= 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (!s_bvalid && !s_rvalid));

  // R10
  b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

  // R10
  r_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));

  // R9
  b_after_both_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(s_bvalid) |-> (aw_seen && w_seen));

  // R9
  single_aw_chk: assert property (@(posedge clk) disable iff (rst)
    (s_awvalid && s_awready) |-> !aw_seen);

  // R7
  decerr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && s_rresp == 2'b11) |-> (s_rdata == '0));

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    s_rvalid |-> (s_rdata[DATA_W-1:GPIO_W] == '0));

  // R8
  pattern_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $stable(gpi) && $past($stable(gpi)) && gpi != '0)
      |-> (gpo == PATTERN));
endmodule

bind gpio_axil_slave gpio_axil_chk #(.DATA_W(DATA_W), .GPIO_W(GPIO_W), .PATTERN(PATTERN)) u_chk (
  .clk(clk), .rst(rst),
  .s_awvalid(s_awvalid), .s_awready(s_awready),
  .s_wvalid(s_wvalid), .s_wready(s_wready),
  .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .gpi(gpi), .gpo(gpo)
);

// File: tb/tb_gpio_axil_slave.sv
module tb_gpio_axil_slave;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int GPIO_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] s_awaddr = '0;
  logic              s_awvalid = 1'b0;
  logic              s_awready;
  logic [DATA_W-1:0] s_wdata = '0;
  logic [3:0]        s_wstrb = '0;
  logic              s_wvalid = 1'b0;
  logic              s_wready;
  logic [1:0]        s_bresp;
  logic              s_bvalid;
  logic              s_bready = 1'b0;
  logic [ADDR_W-1:0] s_araddr = '0;
  logic              s_arvalid = 1'b0;
  logic              s_arready;
  logic [DATA_W-1:0] s_rdata;
  logic [1:0]        s_rresp;
  logic              s_rvalid;
  logic              s_rready = 1'b0;
  logic [GPIO_W-1:0] gpi = '0;
  logic [GPIO_W-1:0] gpo;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_axil_slave dut (
    .clk(clk), .rst(rst),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .gpi(gpi), .gpo(gpo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mode 0: together, 1: address first, 2: data first
  task automatic axi_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] st,
                        input int mode, input int stall, output logic [1:0] resp);
    bit aw_done = 0, w_done = 0, hs_aw, hs_w;
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = st;
    if (mode != 2) s_awvalid = 1'b1;
    if (mode != 1) s_wvalid = 1'b1;
    while (!(aw_done && w_done)) begin
      hs_aw = s_awvalid && s_awready;
      hs_w  = s_wvalid && s_wready;
      @(negedge clk);
      if (hs_aw) begin s_awvalid = 1'b0; aw_done = 1; end
      if (hs_w)  begin s_wvalid = 1'b0;  w_done = 1; end
      if (mode == 1 && aw_done && !w_done && !s_wvalid) begin
        chk("R9 awready low while held", 32'(s_awready), 32'd0);
        s_wvalid = 1'b1;
      end
      if (mode == 2 && w_done && !aw_done && !s_awvalid) begin
        chk("R9 wready low while held", 32'(s_wready), 32'd0);
        s_awvalid = 1'b1;
      end
    end
    while (!s_bvalid) @(negedge clk);
    resp = s_bresp;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R10 bvalid held", 32'(s_bvalid), 32'd1);
      chk("R10 bresp stable", 32'(s_bresp), 32'(resp));
    end
    s_bready = 1'b1;
    @(negedge clk);
    s_bready = 1'b0;
  endtask

  task automatic axi_rd(input logic [ADDR_W-1:0] a, input int stall,
                        output logic [31:0] d, output logic [1:0] resp);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata; resp = s_rresp;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R10 rvalid held", 32'(s_rvalid), 32'd1);
      chk("R10 rdata stable", s_rdata, d);
    end
    s_rready = 1'b1;
    @(negedge clk);
    s_rready = 1'b0;
  endtask

  task automatic set_gpi(input logic [7:0] v);
    @(negedge clk);
    gpi = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_gpo(input logic [7:0] in_v, input logic [7:0] st);
    return (in_v == 8'h00) ? st : 8'h55;
  endfunction

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0]  r;
    logic [31:0] d;
    logic [7:0]  stored = 8'h00;

    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 bvalid", 32'(s_bvalid), 32'd0);
    chk("R1 rvalid", 32'(s_rvalid), 32'd0);
    chk("R1 gpo", 32'(gpo), 32'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 gpo after release", 32'(gpo), 32'h00);

    // R4 R8: full sweep of stored byte, input at zero, all arrival orders
    for (int v = 0; v < 256; v++) begin
      axi_wr(12'h004, {24'hA5C3F0, 8'(v)}, 4'hF, v % 3, 0, r);
      stored = 8'(v);
      chk("R4 write resp", 32'(r), 32'(2'b00));
      chk("R8 gpo follows stored", 32'(gpo), 32'(exp_gpo(8'h00, stored)));
      axi_rd(12'h004, 0, d, r);
      chk("R4 readback", d, {24'h0, stored});
      chk("R4 read resp", 32'(r), 32'(2'b00));
    end

    // R5 strobe bit 0 clear
    axi_wr(12'h004, 32'h0000_0011, 4'hE, 0, 0, r);
    chk("R5 resp", 32'(r), 32'(2'b00));
    axi_rd(12'h004, 0, d, r);
    chk("R5 unchanged", d, {24'h0, stored});

    axi_wr(12'h004, 32'h0000_003C, 4'h1, 1, 0, r);
    stored = 8'h3C;

    // R3 two-flop latency
    @(negedge clk); gpi = 8'h01;
    @(negedge clk);
    chk("R3 after one edge", 32'(gpo), 32'h3C);
    @(negedge clk);
    chk("R3 after two edges", 32'(gpo), 32'h55);

    // R2 R8: full sweep of input byte
    for (int v = 0; v < 256; v++) begin
      set_gpi(8'(v));
      chk("R8 gpo select", 32'(gpo), 32'(exp_gpo(8'(v), stored)));
      axi_rd(12'h000, 0, d, r);
      chk("R2 input readback", d, {24'h0, 8'(v)});
      chk("R2 resp", 32'(r), 32'(2'b00));
    end

    // R6 write to read-only word
    set_gpi(8'h00);
    axi_wr(12'h000, 32'h0000_00EE, 4'hF, 2, 0, r);
    chk("R6 slverr", 32'(r), 32'(2'b10));
    axi_rd(12'h004, 0, d, r);
    chk("R6 output unchanged", d, {24'h0, stored});
    axi_rd(12'h000, 0, d, r);
    chk("R6 input readback unchanged", d, 32'h0);
    chk("R6 gpo unchanged", 32'(gpo), 32'(stored));

    // R7 unmapped words
    axi_rd(12'h008, 0, d, r);
    chk("R7 read decerr", 32'(r), 32'(2'b11));
    chk("R7 read zero", d, 32'h0);
    axi_rd(12'hFFC, 0, d, r);
    chk("R7 top read decerr", 32'(r), 32'(2'b11));
    chk("R7 top read zero", d, 32'h0);
    axi_wr(12'h010, 32'h0000_0099, 4'hF, 0, 0, r);
    chk("R7 write decerr", 32'(r), 32'(2'b11));
    axi_wr(12'h804, 32'h0000_0077, 4'hF, 1, 0, r);
    chk("R7 aliased write decerr", 32'(r), 32'(2'b11));
    axi_rd(12'h004, 0, d, r);
    chk("R7 output unchanged", d, {24'h0, stored});
    chk("R7 gpo unchanged", 32'(gpo), 32'(stored));

    // R10 stalled response channels
    axi_wr(12'h004, 32'h0000_00C7, 4'h1, 2, 3, r);
    stored = 8'hC7;
    chk("R10 write resp", 32'(r), 32'(2'b00));
    axi_rd(12'h004, 3, d, r);
    chk("R10 read value", d, {24'h0, stored});
    axi_rd(12'h00C, 2, d, r);
    chk("R10 stalled decerr", 32'(r), 32'(2'b11));

    // R1 reset mid-run clears the stored byte
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 re-reset gpo", 32'(gpo), 32'h00);
    @(negedge clk); rst = 1'b0;
    axi_rd(12'h004, 0, d, r);
    chk("R1 re-reset readback", d, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule